// File: doc/BRIEF.md
# VCO Coarse-Band Calibration Sequencer

This sequencer picks the coarse band of a switched-capacitor VCO inside an integer-N PLL. After a start pulse it runs one initialization step: it opens the loop, forces the tuning voltage to mid-supply and loads a mid-scale band code. After that, two phases alternate. In the closed-loop phase the PLL runs for a settling time, and then a pair of external window comparators are sampled. They report whether the tuning voltage lies above the upper threshold or below the lower one. In the open-loop phase the tuning voltage is held at mid-supply again while the next band code is applied. Each comparison therefore starts from mid-supply, so each step only has to look at half of the tuning-voltage range.

The band code is refined one bit per comparison, most significant bit first. Calibration stops in one of two ways. If both comparators are quiet at a sample, the tuning voltage is inside the window. Otherwise the search stops once the last bit has been decided, and a flag is raised to show that the window was never reached. When calibration is done, the loop stays closed, the preset is released and the code is held until the next start.

States: `S_IDLE` (after reset), `S_INIT` (loop open, preset, mid-scale code), `S_SETTLE` (loop closed, waiting), `S_SAMPLE` (one cycle, decision), `S_PRESET` (loop open between comparisons), `S_DONE`. The transitions are:
- `S_IDLE` or `S_DONE` on start → `S_INIT`
- `S_INIT` when its timer expires → `S_SETTLE`
- `S_SETTLE` when its timer expires → `S_SAMPLE`
- `S_SAMPLE` in window → `S_DONE`
- `S_SAMPLE` out of window on the last bit → `S_DONE` with the flag set
- `S_SAMPLE` otherwise → `S_PRESET`
- `S_PRESET` when its timer expires → `S_SETTLE`

Top module: `vco_band_cal`

## Requirements
- R1: After reset, `band_code` is mid-scale (only the MSB set, 10000 for 5 bits), and `loop_open`, `vtune_preset`, `done` and `timeout` are all 0.
- R2: A `start` pulse seen in idle or done state begins initialization on the next cycle. The code becomes mid-scale, the flag clears, and the loop is held open with the preset on for max(`preset_cycles`,1) cycles.
- R3: `vtune_preset` is high exactly in the cycles where `loop_open` is high.
- R4: After every open phase, the loop stays closed for max(`settle_cycles`,1) cycles plus one sample cycle. The comparators pass through a two-flop synchronizer, so `settle_cycles` must be at least 3.
- R5: At a sample, `cmp_hi`=1 keeps the bit under trial set and `cmp_lo`=1 clears it, with `cmp_hi` winning if both are set. The next lower bit is then set as the new trial bit.
- R6: If both comparators are 0 at a sample, calibration ends with the code unchanged and `timeout`=0. This also holds when the sample is the one for the LSB.
- R7: If the LSB has been decided without the window being met, calibration ends with `timeout`=1 and the code includes that last decision.
- R8: Between two comparisons there is one open phase of max(`preset_cycles`,1) cycles. A calibration of k comparisons therefore has k open phases and lasts k·(P+S+1) cycles. `band_code` changes only while the loop is open or on entry to done.
- R9: A `start` pulse during calibration is ignored: initialization is not re-entered and the result and timing are unchanged.
- R10: While `done`=1, `loop_open`=0, `vtune_preset`=0 and `band_code` is frozen, whatever the comparators do, until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start / power-on pulse |
| settle_cycles | input | CNT_W | Closed-loop settling length in cycles |
| preset_cycles | input | CNT_W | Open-loop preset length in cycles |
| cmp_hi | input | 1 | Tuning voltage above upper threshold (asynchronous) |
| cmp_lo | input | 1 | Tuning voltage below lower threshold (asynchronous) |
| band_code | output | CODE_W | VCO coarse band code |
| loop_open | output | 1 | Opens the PLL loop |
| vtune_preset | output | 1 | Forces the tuning voltage to mid-supply |
| done | output | 1 | Calibration finished |
| timeout | output | 1 | Finished without meeting the window |

## Verification
Two endings can fall in the same sample cycle: the window is met, and the last bit has been decided. The bench provokes this with a target band whose LSB is 1, so the match happens on the final trial. It judges the outcome by `timeout` staying 0 with the code equal to the target. A target of 0 gives the opposite case, a last-bit ending with the flag set. A separate scenario sends a start pulse while calibration is busy and checks that the phase count and duration do not change.

// File: rtl/band_cal_pkg.sv
package band_cal_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_INIT,
        S_SETTLE,
        S_SAMPLE,
        S_PRESET,
        S_DONE
    } cal_state_t;
endpackage

// File: rtl/cmp_sync2.sv
module cmp_sync2 #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/cal_phase_timer.sv
module cal_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] len,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= (len == '0) ? '0 : len - W'(1);
        else if (cnt != '0)
            cnt <= cnt - W'(1);
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/band_sar.sv
module band_sar #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init,
    input  logic         step,
    input  logic         go_up,
    output logic [W-1:0] code,
    output logic         last
);
    localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] mask;
    logic [W-1:0] code_nxt;

    always_comb begin
        code_nxt = go_up ? code : (code & ~mask);
        if (!mask[0])
            code_nxt = code_nxt | (mask >> 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code <= MID;
            mask <= MID;
        end else if (init) begin
            code <= MID;
            mask <= MID;
        end else if (step) begin
            code <= code_nxt;
            if (!mask[0])
                mask <= mask >> 1;
        end
    end

    assign last = mask[0];

    assert_trial_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mask) == 1);
    assert_step_keeps_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !init && !mask[0]) |=> code[0] == 1'b0 || last);
endmodule

// File: rtl/vco_band_cal.sv
module vco_band_cal
    import band_cal_pkg::*;
#(
    parameter int CODE_W = 5,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  settle_cycles,
    input  logic [CNT_W-1:0]  preset_cycles,
    input  logic              cmp_hi,
    input  logic              cmp_lo,
    output logic [CODE_W-1:0] band_code,
    output logic              loop_open,
    output logic              vtune_preset,
    output logic              done,
    output logic              timeout
);
    localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};

    cal_state_t state_q, state_d;
    logic [1:0] cmp_s;
    logic       hi_s, lo_s;
    logic       tmr_load, tmr_exp;
    logic [CNT_W-1:0] tmr_len;
    logic       sar_init, sar_step, sar_last;
    logic       set_flag, clr_flag;
    logic       flag_q;

    cmp_sync2 #(.W(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({cmp_hi, cmp_lo}), .q(cmp_s)
    );
    assign hi_s = cmp_s[1];
    assign lo_s = cmp_s[0];

    cal_phase_timer #(.W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .len(tmr_len), .expired(tmr_exp)
    );

    band_sar #(.W(CODE_W)) u_sar (
        .clk(clk), .rst_n(rst_n), .init(sar_init), .step(sar_step),
        .go_up(hi_s), .code(band_code), .last(sar_last)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        sar_init = 1'b0;
        sar_step = 1'b0;
        set_flag = 1'b0;
        clr_flag = 1'b0;
        unique case (state_q)
            S_IDLE, S_DONE: begin
                if (start) begin
                    state_d  = S_INIT;
                    sar_init = 1'b1;
                    tmr_load = 1'b1;
                    clr_flag = 1'b1;
                end
            end
            S_INIT, S_PRESET: begin
                if (tmr_exp) begin
                    state_d  = S_SETTLE;
                    tmr_load = 1'b1;
                end
            end
            S_SETTLE: begin
                if (tmr_exp)
                    state_d = S_SAMPLE;
            end
            S_SAMPLE: begin
                if (!hi_s && !lo_s) begin
                    state_d = S_DONE;
                end else begin
                    sar_step = 1'b1;
                    if (sar_last) begin
                        state_d  = S_DONE;
                        set_flag = 1'b1;
                    end else begin
                        state_d  = S_PRESET;
                        tmr_load = 1'b1;
                    end
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    assign tmr_len = (state_d == S_SETTLE) ? settle_cycles : preset_cycles;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (clr_flag)
            flag_q <= 1'b0;
        else if (set_flag)
            flag_q <= 1'b1;
    end

    always_comb begin
        loop_open    = 1'b0;
        vtune_preset = 1'b0;
        done         = 1'b0;
        unique case (state_q)
            S_INIT, S_PRESET: begin
                loop_open    = 1'b1;
                vtune_preset = 1'b1;
            end
            S_DONE:  done = 1'b1;
            default: ;
        endcase
    end

    assign timeout = flag_q;

    assert_start_inits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (state_q == S_IDLE || state_q == S_DONE)) |=>
            (loop_open && band_code == MID_CODE && !timeout));
    assert_code_moves_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(band_code) |-> (loop_open || done));
    assert_no_reinit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_INIT && $past(state_q) != S_INIT) |->
            ($past(state_q) == S_IDLE || $past(state_q) == S_DONE));
    assert_done_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(done) && done) |-> ($stable(band_code) && !loop_open && !vtune_preset));
    assert_sample_closed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SAMPLE) |-> ($past(!loop_open) && !loop_open));
endmodule

// File: tb/vco_band_cal_bench.sv
module vco_band_cal_bench;
    localparam int CODE_W = 5;
    localparam int CNT_W  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [CNT_W-1:0] settle_cycles = 8'd4;
    logic [CNT_W-1:0] preset_cycles = 8'd3;
    logic cmp_hi, cmp_lo;
    logic [CODE_W-1:0] band_code;
    logic loop_open, vtune_preset, done, timeout;

    int target = 0;
    bit stuck_hi = 1'b0;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    // Comparators: only meaningful while the loop runs closed
    assign cmp_hi = stuck_hi ? 1'b1 : (!loop_open && (int'(band_code) < target));
    assign cmp_lo = stuck_hi ? 1'b0 : (!loop_open && (int'(band_code) > target));

    vco_band_cal #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_vco_band_cal (
        .clk(clk), .rst_n(rst_n), .start(start),
        .settle_cycles(settle_cycles), .preset_cycles(preset_cycles),
        .cmp_hi(cmp_hi), .cmp_lo(cmp_lo), .band_code(band_code),
        .loop_open(loop_open), .vtune_preset(vtune_preset),
        .done(done), .timeout(timeout)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Successive-approximation model from R5..R7
    task automatic model(input int t, input bit hi_always,
                         output int steps, output int code, output bit flag);
        int mask = 1 << (CODE_W-1);
        code = mask; steps = 0; flag = 0;
        for (int i = 0; i < CODE_W; i++) begin
            steps++;
            if (!hi_always && code == t) return;
            if (!(hi_always || code < t)) code = code & ~mask;
            if (mask == 1) begin flag = 1; return; end
            mask = mask >> 1;
            code = code | mask;
        end
    endtask

    task automatic run_cal(input int t, input bit hi_always, input int s, input int p,
                           input int poke_at);
        int steps, exp_code, total, open_cyc, phases, mism;
        bit exp_flag, prev_open;
        int se = (s == 0) ? 1 : s;
        int pe = (p == 0) ? 1 : p;
        target = t; stuck_hi = hi_always;
        settle_cycles = CNT_W'(s); preset_cycles = CNT_W'(p);
        model(t, hi_always, steps, exp_code, exp_flag);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        total = 0; open_cyc = 0; phases = 0; mism = 0; prev_open = 0;
        while (!done && total < 5000) begin
            total++;
            if (loop_open) open_cyc++;
            if (loop_open && !prev_open) phases++;
            if (loop_open != vtune_preset) mism++;
            prev_open = loop_open;
            if (total == poke_at) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        check(band_code == CODE_W'(exp_code), "R5 final code", band_code, exp_code);
        check(timeout == exp_flag, exp_flag ? "R7 flag" : "R6 flag", timeout, exp_flag);
        check(phases == steps, "R8 open phases", phases, steps);
        check(open_cyc == steps * pe, "R2 open cycles", open_cyc, steps * pe);
        check(total == steps * (pe + se + 1), "R4 duration", total, steps * (pe + se + 1));
        check(mism == 0, "R3 preset pairing", mism, 0);
    endtask

    task automatic t_reset;
        check(band_code == 5'b10000, "R1 code", band_code, 16);
        check({loop_open, vtune_preset, done, timeout} == 4'b0, "R1 flags",
              {loop_open, vtune_preset, done, timeout}, 0);
    endtask

    task automatic t_window_and_last;     // R6: match lands on LSB trial
        run_cal(11, 0, 4, 3, 0);
    endtask

    task automatic t_first_hit;           // R6: mid-scale already in window
        run_cal(16, 0, 3, 5, 0);
    endtask

    task automatic t_bottom;              // R7: exhausted at code 0
        run_cal(0, 0, 3, 2, 0);
    endtask

    task automatic t_top;                 // R5
        run_cal(31, 0, 5, 3, 0);
    endtask

    task automatic t_stuck;               // R7: window never met
        run_cal(99, 1, 3, 3, 0);
    endtask

    task automatic t_busy_start;          // R9
        run_cal(7, 0, 4, 3, 6);
        run_cal(21, 0, 4, 3, 20);
    endtask

    task automatic t_zero_preset;         // R2 zero length acts as one
        run_cal(5, 0, 3, 0, 0);
    endtask

    task automatic t_done_hold;           // R10
        logic [CODE_W-1:0] held = band_code;
        int bad = 0;
        stuck_hi = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (band_code != held || loop_open || vtune_preset || !done) bad++;
        end
        check(bad == 0, "R10 frozen while done", bad, 0);
        stuck_hi = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_window_and_last();
        t_done_hold();
        t_first_hit();
        t_bottom();
        t_top();
        t_stuck();
        t_busy_start();
        t_zero_preset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule